// File: doc/BRIEF.md
# Instruction Address Sequencer with Branch Source Selection

This block holds the instruction address of a small byte-serial processor. The address register is a chain of 4-bit up counters. Each digit's carry-out enables the digit above it. A parallel load can replace the count with an address taken from one of three places: the return-stack top, the H:L register pair, or a temporary address register. The temporary register collects the two inline address bytes of a jump or a call, low byte first.

The source multiplexer is decoded from the opcode class on every cycle, whatever the opcode is. Its output is visible as the memory-reference address. A load happens only when the execute strobe marks the qualification point of a jump, call or return that is taken. A call raises a push request that carries the current address, and on the same edge the target is loaded. A return raises a pop request, and the stack top it receives is loaded. A conditional jump is taken only when the carry flag is clear.

Top module: `iaddr_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and both `push_o` and `pop_o` are 0.
- R2: With `exec_i` low, a cycle with `step_i` high advances `pc_o` by one on the next edge. A cycle with `step_i` low leaves `pc_o` unchanged.
- R3: Increments carry across the 4-bit digits (0x0FF becomes 0x100), and the all-ones address wraps to 0.
- R4: Op class encoding is 00 other, 01 jump, 10 call, 11 return. `lo_stb_i` and `hi_stb_i` write `imm_byte_i` into the low or the high byte of the temporary address only while the class is jump or call. Under other or return they change nothing.
- R5: `exec_i` with class jump and `cond_i` low loads the temporary address into `pc_o` on the next edge.
- R6: `exec_i` with class jump and `cond_i` high loads the target only if `carry_i` is 0. If `carry_i` is 1, `pc_o` steps or holds as in R2.
- R7: `exec_i` with class call sets `push_o` in the same cycle, with `push_addr_o` equal to the current `pc_o`. On the next edge `pc_o` takes the temporary address.
- R8: `exec_i` with class return sets `pop_o` in the same cycle, and `pc_o` takes `stack_top_i` on the next edge.
- R9: When a load is taken in the same cycle as `step_i`, the load wins.
- R10: `src_addr_o` shows the selected source in every cycle: H:L for class other, the temporary address for jump and call, and `stack_top_i` for return. `exec_i` with class other loads nothing.
- R11: Address bits at or above ADDR_W (default 14) from H:L or from the immediate high byte are dropped. `pc_o` is ADDR_W bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Increment strobe |
| exec_i | input | 1 | Branch qualification strobe |
| op_class_i | input | 2 | Opcode class (00 other, 01 jump, 10 call, 11 return) |
| cond_i | input | 1 | Jump is conditional on carry being false |
| carry_i | input | 1 | Carry flag |
| lo_stb_i | input | 1 | Capture immediate low byte |
| hi_stb_i | input | 1 | Capture immediate high byte |
| imm_byte_i | input | 8 | Inline address byte |
| h_reg_i | input | 8 | H register |
| l_reg_i | input | 8 | L register |
| stack_top_i | input | ADDR_W | Return-stack top |
| pc_o | output | ADDR_W | Current instruction address |
| src_addr_o | output | ADDR_W | Selected load source / memory reference address |
| push_o | output | 1 | Push request to return stack |
| push_addr_o | output | ADDR_W | Address to push |
| pop_o | output | 1 | Pop request to return stack |

## Verification
The push and pop requests and the source multiplexer output are combinational. They are due in the same cycle as the stimulus, so they are compared one time unit after the inputs settle. `pc_o` and the temporary register pass through one register stage each, so a new address is due one edge after the stimulus. The driver queues that expected address, and the monitor compares it at the next falling edge. The effect of the temporary-register strobes is seen one cycle later, through `src_addr_o` and through the target of a later jump.

// File: rtl/iaddr_pkg.sv
package iaddr_pkg;
  typedef enum logic [1:0] {
    OPC_OTHER = 2'b00,
    OPC_JUMP  = 2'b01,
    OPC_CALL  = 2'b10,
    OPC_RET   = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    SRC_HL    = 2'b00,
    SRC_TEMP  = 2'b01,
    SRC_STACK = 2'b10
  } src_sel_e;
endpackage

// File: rtl/iaddr_digit.sv
module iaddr_digit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         cin_i,
  output logic [W-1:0] q_o,
  output logic         cout_o
);
  logic [W-1:0] q_r, q_n;

  always_comb begin
    q_n = q_r;
    if (ld_i)       q_n = ld_val_i;
    else if (cin_i) q_n = q_r + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_n;
  end

  assign q_o    = q_r;
  assign cout_o = cin_i & (&q_r);
endmodule

// File: rtl/iaddr_tmp.sv
module iaddr_tmp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        lo_stb_i,
  input  logic        hi_stb_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] addr_o
);
  logic [7:0] lo_r, hi_r, lo_n, hi_n;

  always_comb begin
    lo_n = lo_r;
    hi_n = hi_r;
    if (en_i && lo_stb_i) lo_n = byte_i;
    if (en_i && hi_stb_i) hi_n = byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_r <= '0;
      hi_r <= '0;
    end else begin
      lo_r <= lo_n;
      hi_r <= hi_n;
    end
  end

  assign addr_o = {hi_r, lo_r};
endmodule

// File: rtl/iaddr_branch_ctl.sv
module iaddr_branch_ctl
  import iaddr_pkg::*;
(
  input  logic       exec_i,
  input  logic [1:0] op_class_i,
  input  logic       cond_i,
  input  logic       carry_i,
  output src_sel_e   sel_o,
  output logic       tmp_en_o,
  output logic       load_o,
  output logic       push_o,
  output logic       pop_o
);
  op_class_e cls;
  logic      taken;

  assign cls = op_class_e'(op_class_i);

  always_comb begin
    sel_o    = SRC_HL;
    tmp_en_o = 1'b0;
    taken    = 1'b0;
    unique case (cls)
      OPC_JUMP: begin
        sel_o    = SRC_TEMP;
        tmp_en_o = 1'b1;
        taken    = !cond_i || !carry_i;
      end
      OPC_CALL: begin
        sel_o    = SRC_TEMP;
        tmp_en_o = 1'b1;
        taken    = 1'b1;
      end
      OPC_RET: begin
        sel_o = SRC_STACK;
        taken = 1'b1;
      end
      default: begin
        sel_o = SRC_HL;
        taken = 1'b0;
      end
    endcase
  end

  assign load_o = exec_i && taken;
  assign push_o = exec_i && (cls == OPC_CALL);
  assign pop_o  = exec_i && (cls == OPC_RET);
endmodule

// File: rtl/iaddr_sequencer.sv
module iaddr_sequencer
  import iaddr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              exec_i,
  input  logic [1:0]        op_class_i,
  input  logic              cond_i,
  input  logic              carry_i,
  input  logic              lo_stb_i,
  input  logic              hi_stb_i,
  input  logic [7:0]        imm_byte_i,
  input  logic [7:0]        h_reg_i,
  input  logic [7:0]        l_reg_i,
  input  logic [ADDR_W-1:0] stack_top_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic              pop_o
);
  localparam int NDIG = (ADDR_W + 3) / 4;

  src_sel_e          sel;
  logic              tmp_en, load;
  logic [15:0]       tmp_full;
  logic [ADDR_W-1:0] tmp_addr, hl_addr, mux_addr;
  logic [NDIG:0]     chain;

  iaddr_branch_ctl u_ctl (
    .exec_i     (exec_i),
    .op_class_i (op_class_i),
    .cond_i     (cond_i),
    .carry_i    (carry_i),
    .sel_o      (sel),
    .tmp_en_o   (tmp_en),
    .load_o     (load),
    .push_o     (push_o),
    .pop_o      (pop_o)
  );

  iaddr_tmp u_tmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (tmp_en),
    .lo_stb_i (lo_stb_i),
    .hi_stb_i (hi_stb_i),
    .byte_i   (imm_byte_i),
    .addr_o   (tmp_full)
  );

  assign tmp_addr = tmp_full[ADDR_W-1:0];
  assign hl_addr  = {h_reg_i, l_reg_i}[ADDR_W-1:0];

  always_comb begin
    unique case (sel)
      SRC_TEMP:  mux_addr = tmp_addr;
      SRC_STACK: mux_addr = stack_top_i;
      default:   mux_addr = hl_addr;
    endcase
  end

  assign chain[0] = step_i & ~load;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    localparam int USED = ((ADDR_W - 4*g) >= 4) ? 4 : (ADDR_W - 4*g);
    iaddr_digit #(.W(USED)) u_dig (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_i     (load),
      .ld_val_i (mux_addr[4*g +: USED]),
      .cin_i    (chain[g]),
      .q_o      (pc_o[4*g +: USED]),
      .cout_o   (chain[g+1])
    );
  end

  assign src_addr_o  = mux_addr;
  assign push_addr_o = pc_o;
endmodule

// File: rtl/iaddr_sva.sv
module iaddr_sva
  import iaddr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic              exec_i,
  input logic [1:0]        op_class_i,
  input logic              cond_i,
  input logic              carry_i,
  input logic [ADDR_W-1:0] stack_top_i,
  input logic [ADDR_W-1:0] tmp_addr,
  input logic [ADDR_W-1:0] pc_o,
  input logic              push_o,
  input logic              pop_o
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !exec_i) |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !exec_i) |=> $stable(pc_o));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_class_i == OPC_JUMP && !cond_i) |=> pc_o == $past(tmp_addr));

  a_r6_carry_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_class_i == OPC_JUMP && cond_i && carry_i && !step_i) |=> $stable(pc_o));

  a_r7_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> pc_o == $past(tmp_addr));

  a_r8_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |=> pc_o == $past(stack_top_i));

  a_r10_other_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_class_i == OPC_OTHER && !step_i) |=> $stable(pc_o));

  a_r7_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_o && pop_o));
endmodule

bind iaddr_sequencer iaddr_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_i      (step_i),
  .exec_i      (exec_i),
  .op_class_i  (op_class_i),
  .cond_i      (cond_i),
  .carry_i     (carry_i),
  .stack_top_i (stack_top_i),
  .tmp_addr    (tmp_addr),
  .pc_o        (pc_o),
  .push_o      (push_o),
  .pop_o       (pop_o)
);

// File: tb/tb_iaddr_sequencer.sv
`timescale 1ns/1ps
module tb_iaddr_sequencer;
  localparam int AW = 14;
  localparam logic [AW-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic step_i = 0, exec_i = 0, cond_i = 0, carry_i = 0, lo_stb_i = 0, hi_stb_i = 0;
  logic [1:0] op_class_i = 2'b00;
  logic [7:0] imm_byte_i = 0, h_reg_i = 0, l_reg_i = 0;
  logic [AW-1:0] stack_top_i = '0;
  logic [AW-1:0] pc_o, src_addr_o, push_addr_o;
  logic push_o, pop_o;

  always #4 clk = ~clk;

  iaddr_sequencer #(.ADDR_W(AW)) dut (.*);

  typedef struct { logic [AW-1:0] pc; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [AW-1:0] m_pc = '0;
  logic [7:0] m_lo = 0, m_hi = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: inputs already set at a falling edge; check same-cycle outputs, queue next pc.
  task automatic tick(input string tag);
    logic [AW-1:0] src;
    logic is_br, taken;
    #1;
    is_br = (op_class_i == 2'b01) || (op_class_i == 2'b10);
    case (op_class_i)
      2'b00:   src = {h_reg_i, l_reg_i}[AW-1:0];
      2'b11:   src = stack_top_i;
      default: src = {m_hi, m_lo}[AW-1:0];
    endcase
    chk({tag, " src"}, 32'(src_addr_o), 32'(src));
    chk({tag, " push"}, 32'(push_o), 32'(exec_i && op_class_i == 2'b10));
    chk({tag, " pop"}, 32'(pop_o), 32'(exec_i && op_class_i == 2'b11));
    if (push_o) chk({tag, " push_addr"}, 32'(push_addr_o), 32'(m_pc));
    case (op_class_i)
      2'b01:   taken = !cond_i || !carry_i;
      2'b10:   taken = 1'b1;
      2'b11:   taken = 1'b1;
      default: taken = 1'b0;
    endcase
    if (exec_i && taken) m_pc = src;
    else if (step_i)     m_pc = (m_pc + 1'b1) & MASK;
    if (is_br && lo_stb_i) m_lo = imm_byte_i;
    if (is_br && hi_stb_i) m_hi = imm_byte_i;
    exp_q.push_back('{m_pc, tag});
    @(negedge clk);
  endtask

  task automatic idle();
    step_i = 0; exec_i = 0; cond_i = 0; carry_i = 0;
    lo_stb_i = 0; hi_stb_i = 0; op_class_i = 2'b00;
  endtask

  task automatic load_temp(input logic [1:0] cls, input logic [7:0] lo, input logic [7:0] hi, input string tag);
    idle(); op_class_i = cls; lo_stb_i = 1; imm_byte_i = lo; tick(tag);
    idle(); op_class_i = cls; hi_stb_i = 1; imm_byte_i = hi; tick(tag);
    idle();
  endtask

  // Monitor: pops the expected address one edge after it was queued.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      chk({it.tag, " pc"}, 32'(pc_o), 32'(it.pc));
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset pc", 32'(pc_o), 0);
    chk("R1 reset push", 32'(push_o), 0);
    chk("R1 reset pop", 32'(pop_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 3; i++) begin idle(); step_i = 1; tick("R2 step"); end
    idle(); tick("R2 hold");

    load_temp(2'b01, 8'hFF, 8'h00, "R4 capture");
    idle(); op_class_i = 2'b01; exec_i = 1; tick("R5 jump");
    idle(); step_i = 1; tick("R3 digit carry");

    idle(); op_class_i = 2'b00; lo_stb_i = 1; imm_byte_i = 8'h12; tick("R4 other ignored");
    idle(); op_class_i = 2'b11; hi_stb_i = 1; imm_byte_i = 8'h21; tick("R4 ret ignored");
    idle(); op_class_i = 2'b01; exec_i = 1; tick("R4 target kept");

    load_temp(2'b10, 8'hFF, 8'hFF, "R11 high byte");
    idle(); op_class_i = 2'b01; exec_i = 1; tick("R11 masked jump");
    idle(); step_i = 1; tick("R3 wrap");

    load_temp(2'b01, 8'h40, 8'h05, "R6 setup");
    idle(); op_class_i = 2'b01; exec_i = 1; cond_i = 1; carry_i = 1; step_i = 1; tick("R6 carry set step");
    idle(); op_class_i = 2'b01; exec_i = 1; cond_i = 1; carry_i = 1; tick("R6 carry set hold");
    idle(); op_class_i = 2'b01; exec_i = 1; cond_i = 1; carry_i = 0; tick("R6 carry clear");

    load_temp(2'b01, 8'h77, 8'h01, "R9 setup");
    idle(); op_class_i = 2'b01; exec_i = 1; step_i = 1; tick("R9 load over step");

    load_temp(2'b10, 8'hAB, 8'h2C, "R7 setup");
    idle(); op_class_i = 2'b10; exec_i = 1; step_i = 1; tick("R7 call");

    stack_top_i = 14'h1234;
    idle(); op_class_i = 2'b11; tick("R10 ret select no exec");
    idle(); op_class_i = 2'b11; exec_i = 1; tick("R8 return");

    h_reg_i = 8'hC5; l_reg_i = 8'h3A;
    idle(); op_class_i = 2'b00; exec_i = 1; step_i = 1; tick("R10 other step");
    idle(); op_class_i = 2'b00; exec_i = 1; tick("R10 other hold");
    idle(); op_class_i = 2'b10; tick("R10 call select no exec");
    idle(); tick("R2 final");
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule